// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets a clocked host read and write single bytes in an external asynchronous static RAM. The RAM has a 19-bit address, an 8-bit data bus and three active-low strobes: chip select, write strobe and output enable. The host gives one request at a time on a valid/ready handshake. Each request carries a write flag, an address and write data. The block answers with a one-cycle done pulse. For reads, the captured byte comes with that pulse.

Strobe timing is counted in clock cycles. Each count is the ceiling of a memory timing limit divided by the clock period. The counts are worked out from parameters given in picoseconds, so the same RTL meets the access time, write-pulse width, data-overlap and output-turnoff limits at any clock rate. The write strobe is only ever low while the address is held still. The bidirectional data bus is split into an output value, an output enable and an input value. The controller drives it only around the write pulse. After a read, it waits for the memory's drivers to turn off before it drives the bus again.

Top module: `sram_ctrl`

## Requirements
- R1: During and after reset, req_ready is 1, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and rsp_done is 0.
- R2: req_ready is 1 exactly when the controller is idle. A request is taken on a clock edge where req_valid and req_ready are both 1, and req_ready is 0 in the cycle after. Each request produces exactly one rsp_done pulse, one cycle wide, in a cycle where req_ready is 1 again.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for RD_CYC = ceil(max(tRC, tAA) / Tclk) cycles (9 at the defaults of 8 ns, 70 ns and 70 ns). The bus is sampled at the end of the last of those cycles. rsp_done and the byte on rsp_rdata appear RD_CYC clock edges after the edge that accepted the request.
- R4: A write holds mem_we_n=0 together with mem_ce_n=0 for WP_CYC = ceil(max(tWP, tDW) / Tclk) consecutive cycles (5 at the defaults). It stores req_wdata at req_addr. rsp_done appears 1 + WP_CYC + REC_CYC edges after acceptance, where REC_CYC = max(1, ceil(tWC / Tclk) - WP_CYC - 1). At the defaults this is 9 edges.
- R5: mem_addr changes only on edges where mem_we_n is 1 both before and after the edge. It is constant for the whole write pulse.
- R6: mem_dq_oe is never 1 while mem_oe_n is 0, so the controller and the memory never drive the bus in the same cycle.
- R7: When a write is accepted and the last completed request was a read, TURN_CYC = max(1, ceil(tOHZ / Tclk)) extra cycles (4 at the defaults) pass with all strobes inactive before the write begins. That write then completes 13 edges after acceptance. A write that follows a write gets no extra cycles.
- R8: mem_dq_oe is 1 from the cycle before mem_we_n falls through the cycle after it rises. mem_dq_o does not change while mem_we_n is 0.
- R9: Whenever mem_ce_n is 1, mem_we_n and mem_oe_n are also 1. With no request pending, all strobes stay inactive and the bus is released.
- R10: Data written at any address, including 19'h00000 and 19'h7FFFF, reads back unchanged. Reads of the same address can follow each other, and an overwritten byte returns its newest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle pulse when a request completes |
| rsp_rdata | output | 8 | Byte read, valid with rsp_done after a read |
| mem_addr | output | 19 | Address to the RAM |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Value the controller puts on the data bus |
| mem_dq_oe | output | 1 | 1 while the controller drives the data bus |
| mem_dq_i | input | 8 | Value seen on the data bus |

## Verification
The memory model in the bench returns a wrong byte until a read has lasted its full access time, so capturing one cycle early is caught as a data error. Isolated writes and reads separate the plain write latency from the read latency. Alternating write/read pairs make every write follow a read, which tests the turnaround cycles; runs of writes show that no turnaround is added when none is needed. The address extremes, repeated reads and an overwrite then confirm storage across the full address range. Meanwhile the model checks each write pulse's width, address stability and bus drive, and counts every cycle in which both sides drive the bus.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared types, default timing and cycle-count helpers for sram_ctrl.
// Assumes timing values are given in picoseconds as positive integers.
package sram_ctrl_pkg;

    // Default clock period and memory timing limits, picoseconds
    localparam int DEF_CLK_PS   = 8000;
    localparam int DEF_T_RC_PS  = 70000;
    localparam int DEF_T_AA_PS  = 70000;
    localparam int DEF_T_WC_PS  = 70000;
    localparam int DEF_T_WP_PS  = 35000;
    localparam int DEF_T_DW_PS  = 30000;
    localparam int DEF_T_OHZ_PS = 30000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_RD,
        ST_WSET,
        ST_WPUL,
        ST_WREC
    } ctl_state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    // Rounds a time limit up to whole clock cycles
    function automatic int ceil_div(int num, int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Module: down-counting phase timer. It loads a count of N-1 when a phase
// starts and reports its last cycle when the count reaches zero.
// Assumes the load value fits in CNT_W bits.
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase start, otherwise count down to zero and stay there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
// Module: transaction sequencer. It walks each request through its read,
// turnaround and write phases and registers the strobes from the next
// state, so they change only on clock edges.
// Assumes all cycle counts are at least 1.
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC   = 9,
    parameter int WP_CYC   = 5,
    parameter int REC_CYC  = 3,
    parameter int TURN_CYC = 4,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_last,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output logic             done,
    output strobe_t          strobes
);

    ctl_state_t state_q, state_d;
    strobe_t    strobe_d;
    logic       last_rd_q;
    logic       finish;

    assign ready   = (state_q == ST_IDLE);
    assign accept  = ready && req_valid;
    assign capture = (state_q == ST_RD) && tmr_last;
    assign finish  = tmr_last && ((state_q == ST_RD) || (state_q == ST_WREC));

    // Next-state and timer load selection
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write) begin
                        state_d  = ST_RD;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYC - 1);
                    end else if (last_rd_q) begin
                        state_d  = ST_TURN;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(TURN_CYC - 1);
                    end else begin
                        state_d  = ST_WSET;
                    end
                end
            end
            ST_TURN: if (tmr_last) state_d = ST_WSET;
            ST_RD:   if (tmr_last) state_d = ST_IDLE;
            ST_WSET: begin
                state_d  = ST_WPUL;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_CYC - 1);
            end
            ST_WPUL: begin
                if (tmr_last) begin
                    state_d  = ST_WREC;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REC_CYC - 1);
                end
            end
            ST_WREC: if (tmr_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobe levels for the coming cycle, decoded from the next state
    always_comb begin
        strobe_d.ce_n  = !(state_d inside {ST_RD, ST_WSET, ST_WPUL, ST_WREC});
        strobe_d.oe_n  = !(state_d == ST_RD);
        strobe_d.we_n  = !(state_d == ST_WPUL);
        strobe_d.dq_oe = (state_d inside {ST_WSET, ST_WPUL}) ||
                         ((state_q == ST_WPUL) && (state_d == ST_WREC));
    end

    // State, registered strobes, done pulse and last-operation history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            strobes   <= '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
            done      <= 1'b0;
            last_rd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            strobes <= strobe_d;
            done    <= finish;
            if (finish) begin
                last_rd_q <= (state_q == ST_RD);
            end
        end
    end

endmodule

// File: rtl/sram_ctrl_dpath.sv
// Module: address, write-data and read-data holding registers.
// Assumes accept and capture never occur in the same cycle.
module sram_ctrl_dpath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_out
);

    // Hold the request fields for the whole transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out  <= '0;
            wdata_out <= '0;
        end else if (accept) begin
            addr_out  <= req_addr;
            wdata_out <= req_wdata;
        end
    end

    // Sample the bus at the end of the read access window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_out <= '0;
        end else if (capture) begin
            rdata_out <= bus_in;
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
// Module: top of the asynchronous static RAM sequencer. It derives cycle
// counts from the timing parameters and connects timer, sequencer and data
// registers. Assumes one request in flight and a bus split into out/oe/in.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int CLK_PS    = DEF_CLK_PS,
    parameter int T_RC_PS   = DEF_T_RC_PS,
    parameter int T_AA_PS   = DEF_T_AA_PS,
    parameter int T_WC_PS   = DEF_T_WC_PS,
    parameter int T_WP_PS   = DEF_T_WP_PS,
    parameter int T_DW_PS   = DEF_T_DW_PS,
    parameter int T_OHZ_PS  = DEF_T_OHZ_PS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int RD_CYC   = max2(ceil_div(T_RC_PS, CLK_PS), ceil_div(T_AA_PS, CLK_PS));
    localparam int WP_CYC   = max2(ceil_div(T_WP_PS, CLK_PS), ceil_div(T_DW_PS, CLK_PS));
    localparam int REC_CYC  = max2(1, ceil_div(T_WC_PS, CLK_PS) - WP_CYC - 1);
    localparam int TURN_CYC = max2(1, ceil_div(T_OHZ_PS, CLK_PS));
    localparam int MAX_CYC  = max2(max2(RD_CYC, WP_CYC), max2(REC_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             accept;
    logic             capture;
    strobe_t          strobes;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_ctrl_fsm #(
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .REC_CYC  (REC_CYC),
        .TURN_CYC (TURN_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .accept    (accept),
        .capture   (capture),
        .ready     (req_ready),
        .done      (rsp_done),
        .strobes   (strobes)
    );

    sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (mem_dq_i),
        .addr_out  (mem_addr),
        .wdata_out (mem_dq_o),
        .rdata_out (rsp_rdata)
    );

    assign mem_ce_n  = strobes.ce_n;
    assign mem_we_n  = strobes.we_n;
    assign mem_oe_n  = strobes.oe_n;
    assign mem_dq_oe = strobes.dq_oe;

endmodule

// File: rtl/sram_ctrl_chk.sv
// Module: protocol checker bound to sram_ctrl. It watches only the ports
// and keeps its own count of cycles since the output enable was last low.
// Assumes the default timing parameters unless MIN_GAP is overridden.
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int MIN_GAP = max2(1, ceil_div(DEF_T_OHZ_PS, DEF_CLK_PS))
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);

    logic [7:0] oe_gap_q;

    // Saturating count of cycles since output enable was last active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_gap_q <= 8'hFF;
        end else if (!mem_oe_n) begin
            oe_gap_q <= 8'd0;
        end else if (oe_gap_q != 8'hFF) begin
            oe_gap_q <= oe_gap_q + 8'd1;
        end
    end

    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready); // R2
    AST_ADDR_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n))); // R5
    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R6
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_gap_q >= 8'(MIN_GAP))); // R7
    AST_DRIVE_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_dq_oe)); // R8
    AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe); // R8
    AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_o)); // R8
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_we_n && mem_oe_n)); // R9

endmodule

bind sram_ctrl sram_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctrl_test.sv
// Scoreboard bench for sram_ctrl with a cycle-level model of the RAM.
module sram_ctrl_test;

    localparam int RD_LAT   = 9;
    localparam int WR_LAT   = 9;
    localparam int TURN_LAT = 4;
    localparam int WP_MIN   = 5;
    localparam int ACC_CYC  = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [18:0] req_addr;
    logic [7:0]  req_wdata;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [7:0]  mem_dq_o;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_i;

    always #4 clk = ~clk;

    sram_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int fight_seen = 0;

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 50000) begin
            check(1'b0, "watchdog", cyc, 50000);
            report();
        end
    end

    // ---------------- RAM model ----------------
    logic [7:0]  model_mem [int];
    int          rd_cnt;
    int          wp_cnt;
    logic [18:0] w_addr;
    logic [7:0]  w_data;
    logic        w_drv_ok;
    logic        w_addr_ok;
    logic        model_drv;

    // Cycle-level RAM behaviour: access counting and write commit
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= 0;
            wp_cnt <= 0;
        end else begin
            if (!mem_ce_n && mem_we_n && !mem_oe_n) rd_cnt <= rd_cnt + 1;
            else rd_cnt <= 0;
            if (!mem_ce_n && !mem_we_n) begin
                if (wp_cnt == 0) begin
                    w_addr    <= mem_addr;
                    w_drv_ok  <= mem_dq_oe;
                    w_addr_ok <= 1'b1;
                end else begin
                    w_drv_ok  <= w_drv_ok & mem_dq_oe;
                    w_addr_ok <= w_addr_ok & (mem_addr == w_addr);
                end
                w_data <= mem_dq_o;
                wp_cnt <= wp_cnt + 1;
            end else if (wp_cnt != 0) begin
                model_mem[int'(w_addr)] = w_data;
                check(wp_cnt >= WP_MIN, "R4 write pulse width", wp_cnt, WP_MIN);
                check(w_addr_ok, "R5 address held during pulse", int'(w_addr_ok), 1);
                check(w_drv_ok, "R8 bus driven during pulse", int'(w_drv_ok), 1);
                wp_cnt <= 0;
            end
        end
    end

    always @* begin
        model_drv = !mem_ce_n && mem_we_n && !mem_oe_n;
        if (!model_drv) mem_dq_i = 8'h00;
        else if (rd_cnt < ACC_CYC) mem_dq_i = 8'h3C;
        else if (model_mem.exists(int'(mem_addr))) mem_dq_i = model_mem[int'(mem_addr)];
        else mem_dq_i = 8'h00;
    end

    // Bus contention watch
    always @(negedge clk) if (rst_n && model_drv && mem_dq_oe) fight_seen++;

    // ---------------- Scoreboard ----------------
    typedef struct {
        bit          wr;
        logic [18:0] addr;
        logic [7:0]  data;
        int          acc;
        int          lat;
    } item_t;

    item_t      sb[$];
    logic [7:0] ref_mem [int];
    bit         last_was_read = 1'b0;

    task automatic op(bit wr, logic [18:0] a, logic [7:0] d);
        item_t it;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check(!req_ready, "R2 ready drops after accept", int'(req_ready), 0);
        it.wr   = wr;
        it.addr = a;
        it.acc  = cyc;
        if (wr) begin
            it.lat = last_was_read ? (WR_LAT + TURN_LAT) : WR_LAT;
            it.data = d;
            ref_mem[int'(a)] = d;
        end else begin
            it.lat  = RD_LAT;
            it.data = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
        end
        last_was_read = !wr;
        sb.push_back(it);
    endtask

    // Monitor: pop and compare on every done pulse
    always @(negedge clk) begin : monitor
        item_t it;
        if (rst_n && rsp_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 done without request", 1, 0);
            end else begin
                it = sb.pop_front();
                if (it.wr)
                    check(cyc - it.acc == it.lat,
                          (it.lat > WR_LAT) ? "R7 write latency after read" : "R4 write latency",
                          cyc - it.acc, it.lat);
                else begin
                    check(cyc - it.acc == it.lat, "R3 read latency", cyc - it.acc, it.lat);
                    check(rsp_rdata == it.data, "R3 R10 read data", int'(rsp_rdata), int'(it.data));
                end
            end
        end
    end

    task automatic idle_check(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
                  "R9 idle quiet", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        end
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done,
              "R1 reset state", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done},
              6'b111100);
        rst_n = 1'b1;
        idle_check(3);

        // Writes in a row (no turnaround), address extremes
        op(1'b1, 19'h00000, 8'h11);
        op(1'b1, 19'h7FFFF, 8'hEE);
        op(1'b1, 19'h2AAAA, 8'h55);
        op(1'b1, 19'h55555, 8'hAA);
        // Read-backs, repeated read of one address
        op(1'b0, 19'h00000, 8'h00);
        op(1'b0, 19'h7FFFF, 8'h00);
        op(1'b0, 19'h7FFFF, 8'h00);
        op(1'b0, 19'h2AAAA, 8'h00);
        op(1'b0, 19'h55555, 8'h00);
        // Write after read: turnaround, then overwrite and read back
        op(1'b1, 19'h55555, 8'h96);
        op(1'b0, 19'h55555, 8'h00);
        // Alternating write/read pairs
        for (int i = 0; i < 8; i++) begin
            op(1'b1, 19'h01000 + 19'(i * 4951), 8'(i * 37 + 5));
            op(1'b0, 19'h01000 + 19'(i * 4951), 8'h00);
        end
        // Read earlier data again after many writes
        op(1'b0, 19'h00000, 8'h00);

        while (sb.size() != 0) @(negedge clk);
        idle_check(4);
        check(fight_seen == 0, "R6 no bus contention", fight_seen, 0);
        report();
    end

endmodule